// File: doc/BRIEF.md
# Indirect Rate Table Access Engine

This block holds the ingress rate-metering parameters of a switch: a set of committed-rate entries, one committed-burst entry and one excess-burst entry. Each is 16 bits wide. A host reaches the table only indirectly, through a small synchronous register port. To write an entry, the host first loads the write-data register and then writes a command word. To read an entry, the host writes a command word, waits for the pending flag in the status register to clear, and then reads the read-data register.

A four-state controller sequences every access, and its path is fixed. It stays in `S_IDLE` until a command write is accepted (transition *accept*). It then passes through `S_DECODE` (*decode done*) and `S_ACCESS`. During `S_ACCESS` the table write or the read-data capture takes place (*access done*). It then enters `S_FINISH` and returns to `S_IDLE` (*complete*). The pending flag is high in every state except `S_IDLE`. The metering datapath reads the table through a separate combinational tap. The tap selects a committed-rate entry from a port number, a priority and a rate-mode setting, and it also presents both burst entries.

Top module: `rate_tbl_engine`

## Requirements
- R1: After reset, all host registers read zero, the pending flag is 0 and every table entry is 0 at the tap.
- R2: Host register offsets on `host_addr` are 0 = command, 1 = status (bit 0 = pending), 2 = write data (low 16 bits) and 3 = read data. The command word is bit 7 = read (1) or write (0), bits 6:5 = table type (01 committed rate, 10 committed burst, 11 excess burst, 00 reserved) and bits 4:0 = entry address. The command register reads back bits 7:0 of the last accepted command, and bits 31:8 always read zero.
- R3: Pending rises in the cycle after an accepted command write, stays high for exactly 3 cycles and then clears.
- R4: A write command stores the write-data register into the addressed entry. The two burst types ignore the address field.
- R5: After a read command completes, the read-data register holds the addressed entry. A write command leaves the read-data register unchanged.
- R6: A command write that arrives while pending is high is ignored. The command register keeps its value, no table access takes place and the pending period is not extended.
- R7: A command with reserved type 00 completes with normal timing, changes no entry and loads zero into the read-data register on a read.
- R8: A committed-rate address of 24 or more changes no entry on a write and returns zero on a read.
- R9: In port-and-priority mode (`rate_mode` 10, and 11 behaves the same), `tap_cir` returns entry port×8 + priority[2:0]. An index of 24 or more returns zero.
- R10: In port-only mode (`rate_mode` 01), `tap_cir` returns entry number `tap_port`.
- R11: In priority-only mode (`rate_mode` 00), `tap_cir` returns entry number `tap_prio`. A value of 24 or more returns zero.
- R12: `tap_cbs` and `tap_ebs` always present the committed-burst and excess-burst entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational) |
| rate_mode | input | 2 | Committed-rate mapping mode |
| tap_port | input | 2 | Tap source port |
| tap_prio | input | 5 | Tap priority |
| tap_cir | output | 16 | Selected committed-rate entry |
| tap_cbs | output | 16 | Committed-burst entry |
| tap_ebs | output | 16 | Excess-burst entry |

## Verification
The assertions check several properties on every cycle:
- the exact three-cycle pending window;
- that the controller never accepts a command while busy;
- that the command register holds during a busy period;
- that the read-data register changes only in the access cycle;
- that the burst entries change only on matching writes, so a reserved-type command leaves them alone.

Other behaviours need the bench's scenarios, because each depends on a sequence of accesses:
- that written values return on later reads;
- that out-of-range committed-rate addresses are dropped;
- that each mapping mode selects the right entry at the tap.

// File: rtl/rte_pkg.sv
package rte_pkg;
    typedef enum logic [1:0] {
        TT_RSVD = 2'b00,
        TT_CIR  = 2'b01,
        TT_CBS  = 2'b10,
        TT_EBS  = 2'b11
    } tbl_type_e;

    typedef struct packed {
        logic       rnw;
        tbl_type_e  ttype;
        logic [4:0] addr;
    } cmd_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_DECODE,
        S_ACCESS,
        S_FINISH
    } eng_state_e;

    localparam logic [1:0] OFS_CMD   = 2'd0;
    localparam logic [1:0] OFS_STAT  = 2'd1;
    localparam logic [1:0] OFS_WDATA = 2'd2;
    localparam logic [1:0] OFS_RDATA = 2'd3;

    localparam logic [1:0] RM_PRIO = 2'b00;
    localparam logic [1:0] RM_PORT = 2'b01;
endpackage

// File: rtl/rte_ctrl_fsm.sv
module rte_ctrl_fsm
    import rte_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    output logic accept,
    output logic pending,
    output logic do_access
);
    eng_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (cmd_wr) state_d = S_DECODE;
            S_DECODE: state_d = S_ACCESS;
            S_ACCESS: state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        accept    = 1'b0;
        pending   = 1'b1;
        do_access = 1'b0;
        unique case (state_q)
            S_IDLE:   begin pending = 1'b0; accept = cmd_wr; end
            S_DECODE: ;
            S_ACCESS: do_access = 1'b1;
            S_FINISH: ;
        endcase
    end

    // R3
    pend_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |=> pending ##1 pending ##1 !pending);

    // R6
    accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> $rose(pending));
endmodule

// File: rtl/rte_host_regs.sv
module rte_host_regs
    import rte_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [31:0]       host_wdata,
    input  logic              accept,
    input  logic              pending,
    input  logic              rd_load,
    input  logic [DATA_W-1:0] rd_value,
    output logic              cmd_wr,
    output cmd_t              cmd_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [31:0]       host_rdata
);
    localparam int CMD_W = $bits(cmd_t);

    logic [DATA_W-1:0] rdata_q;
    logic              unused_hi;

    assign unused_hi = ^host_wdata[31:DATA_W];
    assign cmd_wr    = host_we && (host_addr == OFS_CMD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) cmd_q <= cmd_t'(host_wdata[CMD_W-1:0]);
            if (host_we && host_addr == OFS_WDATA) wdata_q <= host_wdata[DATA_W-1:0];
            if (rd_load) rdata_q <= rd_value;
        end
    end

    always_comb begin
        unique case (host_addr)
            OFS_CMD:   host_rdata = 32'(cmd_q);
            OFS_STAT:  host_rdata = {31'b0, pending};
            OFS_WDATA: host_rdata = 32'(wdata_q);
            OFS_RDATA: host_rdata = 32'(rdata_q);
        endcase
    end

    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && pending) |=> $stable(cmd_q));

    // R5
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_load |=> $stable(rdata_q));
endmodule

// File: rtl/rte_table.sv
module rte_table
    import rte_pkg::*;
#(
    parameter int N_ENT  = 24,
    parameter int DATA_W = 16,
    parameter int GRP    = 8,
    parameter int PORT_W = 2,
    parameter int PRIO_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  tbl_type_e         tsel,
    input  logic [4:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        rate_mode,
    input  logic [PORT_W-1:0] tap_port,
    input  logic [PRIO_W-1:0] tap_prio,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] tap_cir,
    output logic [DATA_W-1:0] tap_cbs,
    output logic [DATA_W-1:0] tap_ebs
);
    localparam int IDX_W = $clog2(N_ENT);
    localparam int GRP_W = $clog2(GRP);
    localparam int TAP_W = PORT_W + PRIO_W + 1;

    logic [DATA_W-1:0] rate_q [N_ENT];
    logic [DATA_W-1:0] cbs_q, ebs_q;
    logic              addr_ok, rate_we;
    logic [TAP_W-1:0]  tap_idx;

    assign addr_ok = 32'(addr) < N_ENT;
    assign rate_we = wr_en && (tsel == TT_CIR) && addr_ok;

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) rate_q[g] <= '0;
            else if (rate_we && addr == 5'(g)) rate_q[g] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cbs_q <= '0;
            ebs_q <= '0;
        end else begin
            if (wr_en && tsel == TT_CBS) cbs_q <= wdata;
            if (wr_en && tsel == TT_EBS) ebs_q <= wdata;
        end
    end

    always_comb begin
        unique case (tsel)
            TT_RSVD: rd_data = '0;
            TT_CIR:  rd_data = addr_ok ? rate_q[addr[IDX_W-1:0]] : '0;
            TT_CBS:  rd_data = cbs_q;
            TT_EBS:  rd_data = ebs_q;
        endcase
    end

    always_comb begin
        unique case (rate_mode)
            RM_PRIO: tap_idx = TAP_W'(tap_prio);
            RM_PORT: tap_idx = TAP_W'(tap_port);
            default: tap_idx = TAP_W'(tap_port) * TAP_W'(GRP) + TAP_W'(tap_prio[GRP_W-1:0]);
        endcase
        tap_cir = (32'(tap_idx) < N_ENT) ? rate_q[tap_idx[IDX_W-1:0]] : '0;
    end

    assign tap_cbs = cbs_q;
    assign tap_ebs = ebs_q;

    // R7
    rsvd_nochg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tsel == TT_RSVD) |=> ($stable(cbs_q) && $stable(ebs_q)));

    // R12
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && tsel == TT_CBS) |=> $stable(tap_cbs));
endmodule

// File: rtl/rate_tbl_engine.sv
module rate_tbl_engine
    import rte_pkg::*;
#(
    parameter int N_ENT  = 24,
    parameter int DATA_W = 16,
    parameter int GRP    = 8,
    parameter int PORT_W = 2,
    parameter int PRIO_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    input  logic [1:0]        rate_mode,
    input  logic [PORT_W-1:0] tap_port,
    input  logic [PRIO_W-1:0] tap_prio,
    output logic [DATA_W-1:0] tap_cir,
    output logic [DATA_W-1:0] tap_cbs,
    output logic [DATA_W-1:0] tap_ebs
);
    logic              cmd_wr, accept, pending, do_access;
    cmd_t              cmd_q;
    logic [DATA_W-1:0] wdata_q, tbl_rd;

    rte_ctrl_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr),
        .accept(accept), .pending(pending), .do_access(do_access)
    );

    rte_host_regs #(.DATA_W(DATA_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .accept(accept), .pending(pending),
        .rd_load(do_access && cmd_q.rnw), .rd_value(tbl_rd),
        .cmd_wr(cmd_wr), .cmd_q(cmd_q), .wdata_q(wdata_q), .host_rdata(host_rdata)
    );

    rte_table #(
        .N_ENT(N_ENT), .DATA_W(DATA_W), .GRP(GRP), .PORT_W(PORT_W), .PRIO_W(PRIO_W)
    ) i_tbl (
        .clk(clk), .rst_n(rst_n), .wr_en(do_access && !cmd_q.rnw),
        .tsel(cmd_q.ttype), .addr(cmd_q.addr), .wdata(wdata_q),
        .rate_mode(rate_mode), .tap_port(tap_port), .tap_prio(tap_prio),
        .rd_data(tbl_rd), .tap_cir(tap_cir), .tap_cbs(tap_cbs), .tap_ebs(tap_ebs)
    );
endmodule

// File: tb/test_rate_tbl_engine.sv
`timescale 1ns/1ps
module test_rate_tbl_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [1:0]  rate_mode = 2'b00;
    logic [1:0]  tap_port = '0;
    logic [4:0]  tap_prio = '0;
    logic [15:0] tap_cir, tap_cbs, tap_ebs;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] m_rate [24];
    logic [15:0] m_cbs = '0, m_ebs = '0, last_rd = '0;

    always #2 clk = ~clk;

    rate_tbl_engine i_rate_tbl_engine (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .rate_mode(rate_mode),
        .tap_port(tap_port), .tap_prio(tap_prio), .tap_cir(tap_cir),
        .tap_cbs(tap_cbs), .tap_ebs(tap_ebs)
    );

    // {rnw, type, addr, write data, expected read}
    localparam int NV = 17;
    localparam logic [39:0] VEC [NV] = '{
        {1'b0, 2'b01, 5'd0,  16'h0101, 16'h0000},
        {1'b0, 2'b01, 5'd5,  16'h0505, 16'h0000},
        {1'b0, 2'b01, 5'd8,  16'h0808, 16'h0000},
        {1'b0, 2'b01, 5'd23, 16'h2323, 16'h0000},
        {1'b0, 2'b01, 5'd17, 16'h1717, 16'h0000},
        {1'b0, 2'b10, 5'd0,  16'hBEEF, 16'h0000},
        {1'b0, 2'b11, 5'd0,  16'hCAFE, 16'h0000},
        {1'b1, 2'b01, 5'd5,  16'h0000, 16'h0505},
        {1'b1, 2'b01, 5'd23, 16'h0000, 16'h2323},
        {1'b1, 2'b10, 5'd0,  16'h0000, 16'hBEEF},
        {1'b1, 2'b11, 5'd0,  16'h0000, 16'hCAFE},
        {1'b0, 2'b01, 5'd24, 16'hDEAD, 16'h0000},
        {1'b1, 2'b01, 5'd24, 16'h0000, 16'h0000},
        {1'b0, 2'b00, 5'd1,  16'hAAAA, 16'h0000},
        {1'b1, 2'b00, 5'd1,  16'h0000, 16'h0000},
        {1'b1, 2'b01, 5'd1,  16'h0000, 16'h0000},
        {1'b1, 2'b01, 5'd0,  16'h0000, 16'h0101}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_rd(input logic [1:0] a, output logic [31:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    // issue a command and check the 3-cycle pending window (R3)
    task automatic issue_cmd(input logic [31:0] c);
        logic [31:0] s;
        logic [3:0]  seen;
        host_wr(2'd0, c);
        host_rd(2'd1, s); seen[0] = s[0];
        @(negedge clk); host_rd(2'd1, s); seen[1] = s[0];
        @(negedge clk); host_rd(2'd1, s); seen[2] = s[0];
        @(negedge clk); host_rd(2'd1, s); seen[3] = s[0];
        chk("R3 pending window", 32'(seen), 32'b0111);
    endtask

    function automatic logic [15:0] tap_model(input logic [1:0] m, input logic [1:0] p,
                                              input logic [4:0] q);
        int idx;
        if (m == 2'b00)      idx = int'(q);
        else if (m == 2'b01) idx = int'(p);
        else                 idx = int'(p) * 8 + int'(q[2:0]);
        return (idx < 24) ? m_rate[idx] : 16'h0;
    endfunction

    task automatic tap_chk(input string req, input logic [1:0] m, input logic [1:0] p,
                           input logic [4:0] q);
        rate_mode = m; tap_port = p; tap_prio = q;
        #1;
        chk(req, 32'(tap_cir), 32'(tap_model(m, p, q)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        for (int i = 0; i < 24; i++) m_rate[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        host_rd(2'd0, r); chk("R1 command reg", r, 32'h0);
        host_rd(2'd1, r); chk("R1 status reg", r, 32'h0);
        host_rd(2'd2, r); chk("R1 write-data reg", r, 32'h0);
        host_rd(2'd3, r); chk("R1 read-data reg", r, 32'h0);
        tap_chk("R1 tap entry", 2'b10, 2'd0, 5'd0);
        chk("R1 tap bursts", {tap_cbs, tap_ebs}, 32'h0);

        // table-driven accesses: R4 R5 R7 R8
        for (int v = 0; v < NV; v++) begin
            logic        rnw;
            logic [1:0]  ty;
            logic [4:0]  ad;
            logic [15:0] wd, ex;
            {rnw, ty, ad, wd, ex} = VEC[v];
            if (!rnw) host_wr(2'd2, {16'hFFFF, wd});
            issue_cmd({24'h0, rnw, ty, ad});
            host_rd(2'd3, r);
            if (rnw) begin
                chk("R5 R7 R8 read result", r, 32'(ex));
                last_rd = ex;
            end else begin
                chk("R5 read data kept on write", r, 32'(last_rd));
                if (ty == 2'b01 && ad < 5'd24) m_rate[ad] = wd;
                if (ty == 2'b10) m_cbs = wd;
                if (ty == 2'b11) m_ebs = wd;
            end
        end

        // R4 R8 R7: written entries visible at the tap, bad address left nothing
        tap_chk("R4 tap entry 0", 2'b00, 2'd0, 5'd0);
        tap_chk("R8 entry 1 unchanged", 2'b00, 2'd0, 5'd1);
        chk("R12 burst taps", {tap_cbs, tap_ebs}, 32'hBEEFCAFE);

        // R2 field layout and upper bits read zero: read of committed rate 5
        issue_cmd(32'hABCD_00A5);
        host_rd(2'd0, r); chk("R2 command readback", r, 32'h0000_00A5);
        host_rd(2'd3, r); chk("R2 read via command fields", r, 32'h0505);
        last_rd = 16'h0505;

        // R6 command while pending is ignored
        host_wr(2'd2, 32'h7777);
        host_wr(2'd0, 32'h22);
        host_we = 1'b1; host_addr = 2'd0; host_wdata = 32'hC0;
        @(negedge clk); host_we = 1'b0;
        host_rd(2'd1, r); chk("R6 still pending", r, 32'h1);
        @(negedge clk); host_rd(2'd1, r); chk("R6 still pending 2", r, 32'h1);
        @(negedge clk); host_rd(2'd1, r); chk("R6 pending not extended", r, 32'h0);
        host_rd(2'd0, r); chk("R6 command kept", r, 32'h22);
        host_rd(2'd3, r); chk("R6 no read performed", r, 32'(last_rd));
        m_rate[2] = 16'h7777;

        // R9 R10 R11 tap mapping
        tap_chk("R9 port1 prio0", 2'b10, 2'd1, 5'd0);
        tap_chk("R9 port2 prio1", 2'b10, 2'd2, 5'd1);
        tap_chk("R9 port2 prio7", 2'b10, 2'd2, 5'd7);
        tap_chk("R9 mode 11 alias", 2'b11, 2'd1, 5'd0);
        tap_chk("R9 port3 out of range", 2'b10, 2'd3, 5'd0);
        chk("R9 port2 prio1 value", 32'(tap_model(2'b10, 2'd2, 5'd1)), 32'h1717);
        tap_chk("R10 port2", 2'b01, 2'd2, 5'd9);
        chk("R10 port2 value", 32'(tap_cir), 32'h7777);
        tap_chk("R10 port0", 2'b01, 2'd0, 5'd23);
        tap_chk("R11 prio23", 2'b00, 2'd1, 5'd23);
        tap_chk("R11 prio8", 2'b00, 2'd2, 5'd8);
        tap_chk("R11 prio24 out of range", 2'b00, 2'd0, 5'd24);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule